// File: doc/BRIEF.md
# Battery-Backed SRAM Power-Fail Guard

This block wraps a byte-wide static RAM and protects it during supply disturbances. A host reaches it over an SRAM-style bus with a select, a write strobe, an output-enable request, an address and write data. Three digital indications stand in for the analog side: one says whether the supply is valid (outside the deselect window), one says the supply has climbed past the battery switchover level, and one says whether the battery voltage is adequate.

While the supply is valid the block acts as a plain RAM. When the supply indication drops, the RAM deselects itself. The read drivers turn off, and every bus input is ignored, so no write can land. Each time the switchover indication rises, the battery indication is sampled once. A low reading latches a battery-not-OK flag, which is brought out on a status pin. While that flag is set, the next complete write attempt is thrown away and the flag clears itself. Writes after that commit normally.

All logic runs on one clock with a synchronous active-high reset. A write attempt is the span of cycles during which select and write strobe are both high. It commits, or is counted against the lockout, on the first cycle in which either of them falls.

Top module: `bbram_guard`

## Requirements
- R1: A write attempt is a run of cycles with `sel`=1 and `wr`=1 while `supply_ok`=1. It commits the last address and data seen in that run on the clock edge where `sel` or `wr` is first sampled low. Other locations are not changed.
- R2: A read request is a cycle with `sel`=1, `oe`=1, `wr`=0 and `supply_ok`=1. On the following cycle, `rdata_oe`=1 and `rdata` carries the byte stored at the requested address. In every other cycle, `rdata_oe`=0 and `rdata`=0.
- R3: While `supply_ok`=0, no memory location changes, whatever `sel`, `wr`, `addr` and `wdata` do.
- R4: In any cycle with `supply_ok`=0, `rdata_oe`=0 and `rdata`=0, even if a read was requested in the cycle before.
- R5: If `supply_ok` falls during a write attempt, the attempt is abandoned. The addressed location and all other locations keep their old contents.
- R6: On each clock edge where `above_sw` is sampled 1 after being sampled 0, `batt_low` is loaded with the inverse of `batt_good`. At no other time does `batt_good` affect the block.
- R7: `batt_low` is 0 after reset and stays 0 until a sample under R6 or a write attempt under R8 changes it.
- R8: While `batt_low`=1, the first write attempt that completes under R1 is dropped, leaving memory unchanged. `batt_low` reads 0 on the cycle after that edge.
- R9: After `batt_low` has cleared, later write attempts commit normally under R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select, active high |
| wr | input | 1 | Write strobe, active high |
| oe | input | 1 | Read output-enable request, active high |
| addr | input | ADDR_W | Byte address (11 bits at the default depth of 2048) |
| wdata | input | DATA_W | Write data |
| supply_ok | input | 1 | Supply valid (1) or inside/below the deselect window (0) |
| above_sw | input | 1 | Supply above the battery switchover level |
| batt_good | input | 1 | Battery voltage adequate |
| rdata | output | DATA_W | Read data, 0 when not driven |
| rdata_oe | output | 1 | Tri-state enable for `rdata` |
| batt_low | output | 1 | Battery-not-OK status flag |

## Verification
A write is visible in memory from the edge that samples the end of the strobe, so the bench lowers the strobe at a falling edge and issues the confirming read only after that edge. Read data and its enable are due one edge after the request, and the bench samples them 1 ns after that edge. The deselect forcing of R4 takes effect in the same cycle, so it is checked before the next edge. The battery flag changes one edge after the switchover rise or after the dropped write ends, and it is sampled there, before any other stimulus.

// File: rtl/bbram_pkg.sv
package bbram_pkg;

    typedef enum logic {
        PWR_DESELECT = 1'b0,
        PWR_ACTIVE   = 1'b1
    } pwr_state_e;

    // Write-path decision on an attempt end.
    typedef enum logic [1:0] {
        WR_IDLE    = 2'd0,
        WR_COMMIT  = 2'd1,
        WR_DROPPED = 2'd2
    } wr_outcome_e;

    function automatic pwr_state_e pwr_of(input logic supply_ok);
        return supply_ok ? PWR_ACTIVE : PWR_DESELECT;
    endfunction

    function automatic wr_outcome_e decide(input logic attempt_end, input logic locked);
        if (!attempt_end) return WR_IDLE;
        return locked ? WR_DROPPED : WR_COMMIT;
    endfunction

endpackage

// File: rtl/bbram_supply_mon.sv
module bbram_supply_mon
    import bbram_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic above_sw,
    input  logic batt_good,
    input  logic attempt_end,
    output logic sw_rise,
    output logic batt_low
);
    logic above_q;

    assign sw_rise = above_sw & ~above_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            above_q  <= 1'b0;
            batt_low <= 1'b0;
        end else begin
            above_q <= above_sw;
            if (sw_rise)
                batt_low <= ~batt_good;
            else if (attempt_end && batt_low)
                batt_low <= 1'b0;
        end
    end
endmodule

// File: rtl/bbram_write_gate.sv
module bbram_write_gate
    import bbram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  pwr_state_e        pwr,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              locked,
    output logic              attempt_end,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);
    logic        active_q;
    logic        strobe;
    wr_outcome_e outcome;

    assign strobe      = sel & wr;
    assign attempt_end = active_q & ~strobe & (pwr == PWR_ACTIVE);
    assign outcome     = decide(attempt_end, locked);
    assign mem_we      = (outcome == WR_COMMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
        end else begin
            // Losing supply abandons the attempt in flight.
            active_q <= strobe & (pwr == PWR_ACTIVE);
            if (strobe && pwr == PWR_ACTIVE) begin
                mem_addr <= addr;
                mem_data <= wdata;
            end
        end
    end
endmodule

// File: rtl/bbram_array.sv
module bbram_array #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        rdata <= store[raddr];
    end
endmodule

// File: rtl/bbram_guard.sv
module bbram_guard
    import bbram_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8,
    localparam int ADDR_W = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              supply_ok,
    input  logic              above_sw,
    input  logic              batt_good,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              batt_low
);
    pwr_state_e        pwr;
    logic              attempt_end;
    logic              sw_rise;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data;
    logic [DATA_W-1:0] arr_rdata;
    logic              rd_q;

    assign pwr = pwr_of(supply_ok);

    bbram_supply_mon u_mon (
        .clk(clk), .rst(rst), .above_sw(above_sw), .batt_good(batt_good),
        .attempt_end(attempt_end), .sw_rise(sw_rise), .batt_low(batt_low)
    );

    bbram_write_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wg (
        .clk(clk), .rst(rst), .pwr(pwr), .sel(sel), .wr(wr), .addr(addr),
        .wdata(wdata), .locked(batt_low), .attempt_end(attempt_end),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    bbram_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_data),
        .raddr(addr), .rdata(arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= sel & oe & ~wr & (pwr == PWR_ACTIVE);
    end

    // Deselect forces the drivers off in the same cycle.
    assign rdata_oe = rd_q & (pwr == PWR_ACTIVE);
    assign rdata    = rdata_oe ? arr_rdata : '0;
endmodule

// File: rtl/bbram_guard_chk.sv
module bbram_guard_chk (
    input logic clk,
    input logic rst,
    input logic sel,
    input logic wr,
    input logic supply_ok,
    input logic above_sw,
    input logic batt_good,
    input logic batt_low,
    input logic mem_we,
    input logic attempt_end,
    input logic sw_rise
);
    assert_commit_on_end_R1: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !(sel && wr));

    assert_no_write_deselect_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> supply_ok);

    assert_flag_from_sample_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(batt_low) |-> ($past(above_sw) && !$past(batt_good)));

    assert_flag_clear_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(batt_low) |-> ($past(attempt_end) || $past(sw_rise)));

    assert_lockout_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (batt_low && !sw_rise) |-> !mem_we);

    assert_lockout_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (attempt_end && batt_low && !sw_rise) |=> !batt_low);
endmodule

bind bbram_guard bbram_guard_chk u_chk (
    .clk(clk), .rst(rst), .sel(sel), .wr(wr), .supply_ok(supply_ok),
    .above_sw(above_sw), .batt_good(batt_good), .batt_low(batt_low),
    .mem_we(mem_we), .attempt_end(attempt_end), .sw_rise(sw_rise)
);

// File: tb/bbram_guard_test.sv
`timescale 1ns/1ps
module bbram_guard_test;
    localparam int DEPTH  = 2048;
    localparam int DATA_W = 8;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int NTEST  = 32;

    logic clk = 1'b0;
    logic rst, sel, wr, oe, supply_ok, above_sw, batt_good;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic rdata_oe, batt_low;

    int checks = 0;
    int fails  = 0;
    logic [DATA_W-1:0] model [NTEST];

    always #5 clk = ~clk;

    bbram_guard #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .sel(sel), .wr(wr), .oe(oe), .addr(addr),
        .wdata(wdata), .supply_ok(supply_ok), .above_sw(above_sw),
        .batt_good(batt_good), .rdata(rdata), .rdata_oe(rdata_oe),
        .batt_low(batt_low)
    );

    function automatic logic [ADDR_W-1:0] slot_addr(input int i);
        return ADDR_W'(i * 61 + 3);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; wr = 0;
        @(negedge clk);
    endtask

    task automatic do_read(input string req, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] exp);
        @(negedge clk); sel = 1; oe = 1; wr = 0; addr = a;
        @(posedge clk); #1;
        check(req, rdata_oe, 1);
        check(req, rdata, exp);
        @(negedge clk); sel = 0; oe = 0;
        @(posedge clk); #1;
        check({req, " idle"}, rdata_oe, 0);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(7));
        rst = 1; sel = 0; wr = 0; oe = 0; addr = '0; wdata = '0;
        supply_ok = 1; above_sw = 0; batt_good = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(posedge clk); #1;
        check("R7 reset flag", batt_low, 0);
        check("R2 reset oe", rdata_oe, 0);
        check("R2 reset data", rdata, 0);

        // Healthy power-up
        @(negedge clk); above_sw = 1;
        @(posedge clk); #1;
        check("R6 good battery", batt_low, 0);

        for (int i = 0; i < NTEST; i++) begin
            model[i] = DATA_W'($urandom);
            do_write(slot_addr(i), model[i]);
        end
        for (int k = 0; k < 40; k++) begin
            int i = int'($urandom % NTEST);
            if ($urandom % 2 == 0) begin
                model[i] = DATA_W'($urandom);
                do_write(slot_addr(i), model[i]);
            end else begin
                do_read("R1 random read", slot_addr(i), model[i]);
            end
        end

        // R1: last address/data of a multi-cycle strobe commits
        @(negedge clk); sel = 1; wr = 1; addr = slot_addr(1); wdata = 8'h11;
        @(negedge clk); addr = slot_addr(2); wdata = 8'h22;
        @(negedge clk); wr = 0; sel = 0;
        model[2] = 8'h22;
        do_read("R1 last value", slot_addr(2), 8'h22);
        do_read("R1 neighbour", slot_addr(1), model[1]);

        // R3/R4: deselect
        @(negedge clk); supply_ok = 0; sel = 1; wr = 1; addr = slot_addr(3); wdata = ~model[3];
        @(negedge clk); wr = 0;
        @(negedge clk); sel = 0;
        @(negedge clk); sel = 1; oe = 1; addr = slot_addr(3);
        @(posedge clk); #1;
        check("R4 deselect oe", rdata_oe, 0);
        check("R4 deselect data", rdata, 0);
        @(negedge clk); sel = 0; oe = 0;
        supply_ok = 1;
        do_read("R3 deselect write ignored", slot_addr(3), model[3]);

        // R4: read requested, supply drops in result cycle
        @(negedge clk); sel = 1; oe = 1; addr = slot_addr(4);
        @(negedge clk); supply_ok = 0; sel = 0; oe = 0;
        #1;
        check("R4 same-cycle forcing", rdata_oe, 0);
        @(negedge clk); supply_ok = 1;

        // R5: supply lost mid-write
        @(negedge clk); sel = 1; wr = 1; addr = slot_addr(5); wdata = ~model[5];
        @(negedge clk); supply_ok = 0;
        @(negedge clk); sel = 0; wr = 0;
        @(negedge clk); supply_ok = 1;
        do_read("R5 aborted location", slot_addr(5), model[5]);
        do_read("R5 other location", slot_addr(6), model[6]);

        // R6/R8/R9: low-battery power-up
        @(negedge clk); above_sw = 0;
        @(negedge clk); batt_good = 0; above_sw = 1;
        @(posedge clk); #1;
        check("R6 low battery flag", batt_low, 1);
        @(negedge clk); batt_good = 1;
        @(posedge clk); #1;
        check("R6 no resample", batt_low, 1);
        do_read("R8 read does not clear", slot_addr(7), model[7]);
        check("R8 flag after read", batt_low, 1);
        do_write(slot_addr(7), ~model[7]);
        check("R8 flag cleared", batt_low, 0);
        do_read("R8 dropped write", slot_addr(7), model[7]);
        model[8] = ~model[8];
        do_write(slot_addr(8), model[8]);
        do_read("R9 next write", slot_addr(8), model[8]);
        model[7] = 8'h5a;
        do_write(slot_addr(7), model[7]);
        do_read("R9 second write", slot_addr(7), model[7]);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule